// File: doc/BRIEF.md
# Bus Interface Error Status Register

This block holds the 16-bit status word of a parallel, PCI-style bus interface. Six error flags in the upper byte are sticky. Each one is set by a one-cycle event pulse from the interface's protocol logic. A flag stays set until reset, or until software writes a 1 to its bit position through the register write port. The other bits are read-only and report fixed capabilities and the device-select timing class. The fast back-to-back capability bit depends on the bus mode: it reads 1 in conventional mode and 0 in extended mode.

Two flags have gated or mode-qualified sources. The master parity error flag needs the parity-error-response enable from the command register. The split-completion error message inputs only count in extended mode. The read data is a combinational view of the register, so a flag that was set at a clock edge can be read right after that edge.

Top module: `bus_err_status`

## Requirements
- R1: A synchronous active-low reset clears all sticky flags. After reset the register reads 0x02B0 when `ext_mode`=0 and 0x0230 when `ext_mode`=1.
- R2: Bit 15 (parity detected) sets one clock after any of `ev_wdata_err_tgt`, `ev_rdata_err_req` or `ev_addr_err` is high, whatever the value of `perr_resp_en`.
- R3: Bit 14 (error signal driven) sets one clock after `ev_serr_drv` is high.
- R4: Bit 13 (master abort) sets one clock after `ev_mabort` is high. It also sets after `ev_msg_mabort` is high, but only while `ext_mode`=1; in conventional mode that message input has no effect.
- R5: Bit 12 (target abort received) sets after `ev_tabort_rcv`, or after `ev_msg_tabort` while `ext_mode`=1. Bit 11 (target abort signalled) sets after `ev_tabort_sig`.
- R6: Bit 8 (master parity) sets only while `perr_resp_en`=1. Its sources are `ev_perr_req`, or `ev_msg_wdata_err` while `ext_mode`=1.
- R7: A write with `wr_en`=1 clears each sticky bit whose `wr_data` bit is 1 and whose byte enable is 1. `wr_be[1]` covers bits 15:8 and `wr_be[0]` covers bits 7:0. Bits written with 0, or in a disabled byte, keep their value.
- R8: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R9: The read-only bits ignore writes. Bits 10:9 read 01 (medium timing; 00 fast, 01 medium, 10 slow, 11 reserved). Bit 7 reads the inverse of `ext_mode`. Bit 6 reads 0, bits 5 and 4 read 1, and bits 3:0 read 0.
- R10: A sticky flag stays set after its event input returns low, until it is cleared or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 1 = extended bus mode, 0 = conventional mode |
| perr_resp_en | input | 1 | Parity-error-response enable from the command register |
| ev_wdata_err_tgt | input | 1 | Uncorrectable write-data error received as target |
| ev_rdata_err_req | input | 1 | Uncorrectable read-data error received as requester |
| ev_addr_err | input | 1 | Uncorrectable address or attribute error on the bus |
| ev_serr_drv | input | 1 | Interface drove the system error line |
| ev_mabort | input | 1 | Own transaction ended in master abort |
| ev_msg_mabort | input | 1 | Master-abort split-completion error message received |
| ev_tabort_rcv | input | 1 | Own transaction ended in target abort |
| ev_msg_tabort | input | 1 | Target-abort split-completion error message received |
| ev_tabort_sig | input | 1 | Interface as target terminated with target abort |
| ev_perr_req | input | 1 | Parity error line driven or seen while requester |
| ev_msg_wdata_err | input | 1 | Uncorrectable write-data error message received |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data, 1 = clear |
| wr_be | input | 2 | Byte enables for the write |
| rd_data | output | 16 | Current register value |

## Verification
Each flag source is pulsed on its own while every other input is quiet. This shows that each event lands on its own bit and no other. The message inputs and the parity response enable are each tried in both states, so that gated and ungated paths are told apart. Writes are tried with a zero pattern, with the wrong byte lane, with single-bit clears and with all ones over read-only bits. These cases separate a true per-bit, per-lane clear from a blanket clear. A last case lines up an event and its clear in the same cycle to show that the set has priority.

// File: rtl/esr_pkg.sv
// Package: shared widths, bit positions and read-only values for the
// bus error status register. Assumes a 16-bit register with byte lanes.
package esr_pkg;
    localparam int REG_W   = 16;
    localparam int BE_W    = REG_W / 8;

    localparam int B_PAR_DET  = 15;
    localparam int B_SERR     = 14;
    localparam int B_MABORT   = 13;
    localparam int B_TAB_RCV  = 12;
    localparam int B_TAB_SIG  = 11;
    localparam int B_TIM_HI   = 10;
    localparam int B_TIM_LO   = 9;
    localparam int B_MPAR     = 8;
    localparam int B_FBB      = 7;
    localparam int B_UDF      = 6;
    localparam int B_66M      = 5;
    localparam int B_CAPL     = 4;

    localparam logic [REG_W-1:0] STICKY_MASK =
        (REG_W'(1) << B_PAR_DET) | (REG_W'(1) << B_SERR) |
        (REG_W'(1) << B_MABORT)  | (REG_W'(1) << B_TAB_RCV) |
        (REG_W'(1) << B_TAB_SIG) | (REG_W'(1) << B_MPAR);

    typedef enum logic [1:0] {
        TIM_FAST = 2'b00,
        TIM_MED  = 2'b01,
        TIM_SLOW = 2'b10,
        TIM_RSVD = 2'b11
    } dev_timing_e;
endpackage

// File: rtl/esr_set_decode.sv
// Module: maps the per-cycle event pulses to a per-bit set vector.
// Assumes events are single-cycle qualified pulses from the bus logic;
// message events only count in extended mode, master parity needs the
// response enable.
module esr_set_decode
    import esr_pkg::*;
(
    input  logic             ext_mode,
    input  logic             perr_resp_en,
    input  logic             ev_wdata_err_tgt,
    input  logic             ev_rdata_err_req,
    input  logic             ev_addr_err,
    input  logic             ev_serr_drv,
    input  logic             ev_mabort,
    input  logic             ev_msg_mabort,
    input  logic             ev_tabort_rcv,
    input  logic             ev_msg_tabort,
    input  logic             ev_tabort_sig,
    input  logic             ev_perr_req,
    input  logic             ev_msg_wdata_err,
    output logic [REG_W-1:0] set_vec
);
    // Combine sources for each sticky flag.
    always_comb begin
        set_vec            = '0;
        set_vec[B_PAR_DET] = ev_wdata_err_tgt | ev_rdata_err_req | ev_addr_err;
        set_vec[B_SERR]    = ev_serr_drv;
        set_vec[B_MABORT]  = ev_mabort | (ext_mode & ev_msg_mabort);
        set_vec[B_TAB_RCV] = ev_tabort_rcv | (ext_mode & ev_msg_tabort);
        set_vec[B_TAB_SIG] = ev_tabort_sig;
        set_vec[B_MPAR]    = perr_resp_en &
                             (ev_perr_req | (ext_mode & ev_msg_wdata_err));
    end
endmodule

// File: rtl/esr_flag_cell.sv
// Module: one sticky status bit. Set by hardware, cleared by a write of 1
// or by reset. A set in the same cycle as a clear wins.
module esr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Sticky update with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i | (q & ~clr_i);
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i) |=> q);
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q);
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(set_i));
endmodule

// File: rtl/esr_const_field.sv
// Module: builds the read-only part of the register. The fast
// back-to-back bit follows the bus mode; all others are fixed by parameters.
module esr_const_field
    import esr_pkg::*;
#(
    parameter dev_timing_e TIMING  = TIM_MED,
    parameter bit          FBB_CAP = 1'b1,
    parameter bit          UDF_CAP = 1'b0,
    parameter bit          M66_CAP = 1'b1,
    parameter bit          CAPLIST = 1'b1
) (
    input  logic             ext_mode,
    output logic [REG_W-1:0] ro_val
);
    // Assemble fixed fields; fast back-to-back is absent in extended mode.
    always_comb begin
        ro_val                    = '0;
        ro_val[B_TIM_HI:B_TIM_LO] = TIMING;
        ro_val[B_FBB]             = FBB_CAP & ~ext_mode;
        ro_val[B_UDF]             = UDF_CAP;
        ro_val[B_66M]             = M66_CAP;
        ro_val[B_CAPL]            = CAPLIST;
    end
endmodule

// File: rtl/bus_err_status.sv
// Module: top of the bus interface error status register. Instantiates
// the set decoder, one sticky cell per flag bit and the read-only field.
// Assumes the caller qualifies wr_en with a register-select decode.
module bus_err_status
    import esr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             perr_resp_en,
    input  logic             ev_wdata_err_tgt,
    input  logic             ev_rdata_err_req,
    input  logic             ev_addr_err,
    input  logic             ev_serr_drv,
    input  logic             ev_mabort,
    input  logic             ev_msg_mabort,
    input  logic             ev_tabort_rcv,
    input  logic             ev_msg_tabort,
    input  logic             ev_tabort_sig,
    input  logic             ev_perr_req,
    input  logic             ev_msg_wdata_err,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [BE_W-1:0]  wr_be,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] ro_val;
    logic             unused_bits;

    esr_set_decode u_dec (
        .ext_mode         (ext_mode),
        .perr_resp_en     (perr_resp_en),
        .ev_wdata_err_tgt (ev_wdata_err_tgt),
        .ev_rdata_err_req (ev_rdata_err_req),
        .ev_addr_err      (ev_addr_err),
        .ev_serr_drv      (ev_serr_drv),
        .ev_mabort        (ev_mabort),
        .ev_msg_mabort    (ev_msg_mabort),
        .ev_tabort_rcv    (ev_tabort_rcv),
        .ev_msg_tabort    (ev_msg_tabort),
        .ev_tabort_sig    (ev_tabort_sig),
        .ev_perr_req      (ev_perr_req),
        .ev_msg_wdata_err (ev_msg_wdata_err),
        .set_vec          (set_vec)
    );

    // One sticky cell per flag position; other positions read 0 here.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        assign clr_vec[i] = wr_en & wr_data[i] & wr_be[i/8];
        if (STICKY_MASK[i]) begin : g_sticky
            esr_flag_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q     (flag_q[i])
            );
        end else begin : g_fixed
            assign flag_q[i] = 1'b0;
        end
    end

    esr_const_field u_ro (
        .ext_mode (ext_mode),
        .ro_val   (ro_val)
    );

    // Merge sticky flags with the read-only fields.
    assign rd_data     = flag_q | ro_val;
    assign unused_bits = ^((set_vec | clr_vec) & ~STICKY_MASK);

    p_mpar_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_MPAR]) |-> $past(perr_resp_en));
    p_mabort_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_MABORT]) |->
            ($past(ev_mabort) || $past(ext_mode && ev_msg_mabort)));
    p_serr_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_SERR]) |-> $past(ev_serr_drv));
    p_ro_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ext_mode) |-> $stable(rd_data[B_FBB:0]));
endmodule

// File: tb/bus_err_status_tb.sv
module bus_err_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0, perr_resp_en = 1'b0;
    logic        ev_wdata_err_tgt = 0, ev_rdata_err_req = 0, ev_addr_err = 0;
    logic        ev_serr_drv = 0, ev_mabort = 0, ev_msg_mabort = 0;
    logic        ev_tabort_rcv = 0, ev_msg_tabort = 0, ev_tabort_sig = 0;
    logic        ev_perr_req = 0, ev_msg_wdata_err = 0;
    logic        wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic [15:0] rd_data;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    bus_err_status u_dut (.*);

    localparam logic [15:0] RO_CONV = 16'h02B0;
    localparam logic [15:0] RO_EXT  = 16'h0230;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk);
    endtask

    task automatic clear_events();
        {ev_wdata_err_tgt, ev_rdata_err_req, ev_addr_err, ev_serr_drv,
         ev_mabort, ev_msg_mabort, ev_tabort_rcv, ev_msg_tabort,
         ev_tabort_sig, ev_perr_req, ev_msg_wdata_err} = '0;
        wr_en = 0; wr_data = '0; wr_be = '0;
    endtask

    // Drive the event number k for one cycle (clock edge in between).
    task automatic pulse(int k);
        @(negedge clk);
        case (k)
            0: ev_wdata_err_tgt = 1;  1: ev_rdata_err_req = 1;
            2: ev_addr_err = 1;       3: ev_serr_drv = 1;
            4: ev_mabort = 1;         5: ev_msg_mabort = 1;
            6: ev_tabort_rcv = 1;     7: ev_msg_tabort = 1;
            8: ev_tabort_sig = 1;     9: ev_perr_req = 1;
            default: ev_msg_wdata_err = 1;
        endcase
        @(negedge clk); clear_events();
    endtask

    task automatic wr(logic [15:0] d, logic [1:0] be);
        @(negedge clk); wr_en = 1; wr_data = d; wr_be = be;
        @(negedge clk); clear_events();
    endtask

    task automatic t_reset();
        ext_mode = 0; do_reset();
        check("R1 conv reset", rd_data, RO_CONV);
        ext_mode = 1; do_reset();
        check("R1 ext reset", rd_data, RO_EXT);
        ext_mode = 0; #1;
        check("R9 fbb follows mode", rd_data, RO_CONV);
    endtask

    task automatic t_parity();
        perr_resp_en = 0;
        for (int k = 0; k < 3; k++) begin
            pulse(k);
            check("R2 parity detected", rd_data, RO_CONV | 16'h8000);
            wr(16'h8000, 2'b10);
            check("R7 clear bit15", rd_data, RO_CONV);
        end
    endtask

    task automatic t_serr_abort();
        pulse(3);
        check("R3 serr", rd_data, RO_CONV | 16'h4000);
        @(negedge clk); @(negedge clk);
        check("R10 sticky after pulse", rd_data, RO_CONV | 16'h4000);
        wr(16'h4000, 2'b10);
        pulse(4);
        check("R4 master abort", rd_data, RO_CONV | 16'h2000);
        wr(16'h2000, 2'b10);
        pulse(5);
        check("R4 msg ignored conv", rd_data, RO_CONV);
        pulse(7);
        check("R5 msg ignored conv", rd_data, RO_CONV);
        ext_mode = 1;
        pulse(5);
        check("R4 msg ext", rd_data, RO_EXT | 16'h2000);
        pulse(7);
        check("R5 msg ext", rd_data, RO_EXT | 16'h3000);
        wr(16'h3000, 2'b10);
        ext_mode = 0;
        pulse(6);
        check("R5 target abort rcv", rd_data, RO_CONV | 16'h1000);
        pulse(8);
        check("R5 target abort sig", rd_data, RO_CONV | 16'h1800);
        wr(16'h1800, 2'b10);
    endtask

    task automatic t_mpar();
        perr_resp_en = 0;
        pulse(9);
        check("R6 gated off", rd_data, RO_CONV);
        perr_resp_en = 1;
        pulse(10);
        check("R6 msg ignored conv", rd_data, RO_CONV);
        pulse(9);
        check("R6 perr enabled", rd_data, RO_CONV | 16'h0100);
        wr(16'h0100, 2'b10);
        ext_mode = 1;
        pulse(10);
        check("R6 msg ext", rd_data, RO_EXT | 16'h0100);
        wr(16'h0100, 2'b10);
        perr_resp_en = 0;
        pulse(10);
        check("R6 msg gated off", rd_data, RO_EXT);
        ext_mode = 0;
    endtask

    task automatic t_w1c();
        perr_resp_en = 1;
        for (int k = 0; k < 11; k++) if (k != 5 && k != 7 && k != 10) pulse(k);
        check("R10 all flags", rd_data, 16'hFBB0);
        wr(16'h0000, 2'b11);
        check("R7 zero write", rd_data, 16'hFBB0);
        wr(16'hFFFF, 2'b01);
        check("R7 wrong lane", rd_data, 16'hFBB0);
        wr(16'h4000, 2'b10);
        check("R7 single clear", rd_data, 16'hBBB0);
        wr(16'hFFFF, 2'b11);
        check("R9 ro after ones", rd_data, RO_CONV);
        perr_resp_en = 0;
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        ev_addr_err = 1; wr_en = 1; wr_data = 16'h8000; wr_be = 2'b10;
        @(negedge clk); clear_events();
        check("R8 set wins", rd_data, RO_CONV | 16'h8000);
        wr(16'h8000, 2'b10);
        check("R7 clear after", rd_data, RO_CONV);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_parity();
        t_serr_abort();
        t_mpar();
        t_w1c();
        t_set_wins();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule